// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block chooses the serial link configuration for a display mode. Given the mode's pixel clock (in kHz), the bits per colour component, the largest lane count and link rate the sink advertises, and a flag saying the source may use the 540000 kHz rate, it picks the fewest lanes and then the slowest link rate able to carry the pixel stream. It also reports whether the mode may be used.

A request is presented with a one-cycle `start` pulse while the block is idle. The block derives bits per pixel and forms the bandwidth demand (pixel clock times bits per pixel) with an iterative shift-add multiplier. It then compares this demand against candidate capacities (rate times lanes times 8), one candidate per cycle. No division is used anywhere. The results are registered and held, with `done` high, until the next accepted request. A bridge input forces the 270000 kHz rate. A configuration-present input gates the validity flag.

Top module: `lrs_link_select`

## Requirements
- R1: Bits per pixel is three times `bpc`, except that `bpc` = 0 is treated as 24 bits per pixel.
- R2: `lanes` is binary 1, 2 or 4. Starting from 1, the count doubles while it is below `sink_lanes` and below 4, and stops at the first count where pixel clock times bpp is at most the maximum rate times lanes times 8.
- R3: The maximum rate is the smaller of `sink_rate` and the cap, which is 540000 when `hi_rate_ok` = 1 and 270000 otherwise.
- R4: With the chosen lanes, the rates 162000, then 270000, then 540000 (only if `hi_rate_ok` = 1) are tried in that order, and the first that fits (same test as R2) is chosen. If none fits, the maximum rate from R3 is chosen.
- R5: When `bridge_fix` = 1 the rate is 270000, while lanes still follow R2.
- R6: `mode_ok` is 1 only if `cfg_valid` = 1 and the chosen rate is not 540000 while `hi_rate_ok` = 0.
- R7: `start` while idle captures all inputs, raises `busy` and clears `done`. `start` while `busy` is ignored, and the result is that of the captured request.
- R8: After reset, `busy`, `done`, `lanes`, `rate` and `mode_ok` are 0. The outputs change only in the cycle where `done` rises and are held otherwise, even when inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, accepted only while idle |
| pix_khz | input | PIX_W (20) | Pixel clock in kHz |
| bpc | input | BPC_W (4) | Bits per colour component, 0 = default |
| sink_lanes | input | LANE_W (3) | Sink's maximum lane count |
| sink_rate | input | RATE_W (20) | Sink's maximum link rate in kHz |
| hi_rate_ok | input | 1 | The 540000 kHz rate is allowed |
| bridge_fix | input | 1 | Force the 270000 kHz rate |
| cfg_valid | input | 1 | Sink configuration data is present |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid and held |
| lanes | output | LANE_W (3) | Chosen lane count (1, 2 or 4) |
| rate | output | RATE_W (20) | Chosen link rate in kHz |
| mode_ok | output | 1 | Mode is usable |

## Verification
Pixel clocks are swept across values that fall exactly on and just above the single-lane 162000 capacity at 24 bpp, as well as values that need two lanes, four lanes, or more than any configuration offers. Each is crossed with several colour depths including 0, every sink lane limit, every sink rate, and both states of the high-rate flag. Exact-boundary values separate a less-or-equal fit test from a strict one. The exhausted cases separate the fallback to the maximum rate from the 540000 attempt. Separate runs cover the bridge override, missing configuration, a start pulse during a computation, and input changes after completion.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL,
    ST_LANE,
    ST_RATE,
    ST_FIN
  } lrs_state_e;
endpackage

// File: rtl/lrs_bpp.sv
module lrs_bpp #(
  parameter int BPC_W = 4,
  parameter int BPP_W = BPC_W + 2
) (
  input  logic [BPC_W-1:0] bpc_i,
  output logic [BPP_W-1:0] bpp_o
);
  localparam int DEF_BPP = 24;

  always_comb begin
    if (bpc_i == '0)
      bpp_o = BPP_W'(DEF_BPP);
    else
      bpp_o = BPP_W'(bpc_i) + (BPP_W'(bpc_i) << 1);
  end
endmodule

// File: rtl/lrs_seqmul.sv
module lrs_seqmul #(
  parameter int A_W = 20,
  parameter int B_W = 6,
  localparam int P_W = A_W + B_W,
  localparam int CNT_W = $clog2(B_W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           fin,
  output logic [P_W-1:0] prod
);
  logic [P_W-1:0]   a_sh;
  logic [B_W-1:0]   b_sh;
  logic [P_W-1:0]   acc;
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sh <= '0;
      b_sh <= '0;
      acc  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      fin  <= 1'b0;
    end else if (go) begin
      a_sh <= P_W'(a_i);
      b_sh <= b_i;
      acc  <= '0;
      cnt  <= CNT_W'(B_W);
      run  <= 1'b1;
      fin  <= 1'b0;
    end else if (run) begin
      if (b_sh[0])
        acc <= acc + a_sh;
      a_sh <= a_sh << 1;
      b_sh <= b_sh >> 1;
      cnt  <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign prod = acc;

  // R1
  mul_count_live_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));

  // R1
  mul_go_starts_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> run && !fin);

  // R1
  mul_fin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> !run);
endmodule

// File: rtl/lrs_capacity.sv
module lrs_capacity #(
  parameter int RATE_W = 20,
  parameter int EXP_W = 2,
  parameter int CAP_W = RATE_W + 6
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [EXP_W-1:0]  exp_i,
  output logic [CAP_W-1:0]  cap_o
);
  localparam int BITS_PER_SYM = 3;

  always_comb begin
    cap_o = (CAP_W'(rate_i) << BITS_PER_SYM) << exp_i;
  end
endmodule

// File: rtl/lrs_link_select.sv
module lrs_link_select
  import lrs_pkg::*;
#(
  parameter int PIX_W    = 20,
  parameter int BPC_W    = 4,
  parameter int RATE_W   = 20,
  parameter int LANE_W   = 3,
  parameter int RATE_LO  = 162000,
  parameter int RATE_MID = 270000,
  parameter int RATE_HI  = 540000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PIX_W-1:0]  pix_khz,
  input  logic [BPC_W-1:0]  bpc,
  input  logic [LANE_W-1:0] sink_lanes,
  input  logic [RATE_W-1:0] sink_rate,
  input  logic              hi_rate_ok,
  input  logic              bridge_fix,
  input  logic              cfg_valid,
  output logic              busy,
  output logic              done,
  output logic [LANE_W-1:0] lanes,
  output logic [RATE_W-1:0] rate,
  output logic              mode_ok
);
  localparam int BPP_W   = BPC_W + 2;
  localparam int PROD_W  = PIX_W + BPP_W;
  localparam int MAX_EXP = LANE_W - 1;
  localparam int EXP_W   = (LANE_W > 2) ? $clog2(LANE_W) : 1;
  localparam int CAP_W   = RATE_W + 3 + MAX_EXP;
  localparam int CMP_W   = (PROD_W > CAP_W) ? PROD_W : CAP_W;

  localparam logic [RATE_W-1:0] R_LO  = RATE_W'(RATE_LO);
  localparam logic [RATE_W-1:0] R_MID = RATE_W'(RATE_MID);
  localparam logic [RATE_W-1:0] R_HI  = RATE_W'(RATE_HI);

  lrs_state_e        st;
  logic [LANE_W-1:0] sink_lanes_q;
  logic [RATE_W-1:0] max_rate_q;
  logic              hi_q;
  logic              fix_q;
  logic              cfg_q;
  logic [PROD_W-1:0] demand_q;
  logic [EXP_W-1:0]  exp_q;
  logic [1:0]        rsel_q;
  logic [RATE_W-1:0] pick_q;

  logic [BPP_W-1:0]  bpp;
  logic              mul_go;
  logic              mul_fin;
  logic [PROD_W-1:0] mul_prod;
  logic [RATE_W-1:0] cap_rate;
  logic [CAP_W-1:0]  cap;
  logic              fits;
  logic [LANE_W-1:0] lanes_cur;
  logic [RATE_W-1:0] rate_cap_lim;
  logic [RATE_W-1:0] max_rate_d;

  lrs_bpp #(.BPC_W(BPC_W), .BPP_W(BPP_W)) u_bpp (
    .bpc_i (bpc),
    .bpp_o (bpp)
  );

  assign mul_go = (st == ST_IDLE) && start;

  lrs_seqmul #(.A_W(PIX_W), .B_W(BPP_W)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .go   (mul_go),
    .a_i  (pix_khz),
    .b_i  (bpp),
    .fin  (mul_fin),
    .prod (mul_prod)
  );

  always_comb begin
    cap_rate = max_rate_q;
    if (st == ST_RATE) begin
      case (rsel_q)
        2'd0:    cap_rate = R_LO;
        2'd1:    cap_rate = R_MID;
        default: cap_rate = R_HI;
      endcase
    end
  end

  lrs_capacity #(.RATE_W(RATE_W), .EXP_W(EXP_W), .CAP_W(CAP_W)) u_cap (
    .rate_i (cap_rate),
    .exp_i  (exp_q),
    .cap_o  (cap)
  );

  assign fits       = CMP_W'(demand_q) <= CMP_W'(cap);
  assign lanes_cur  = LANE_W'(1) << exp_q;
  assign rate_cap_lim = hi_rate_ok ? R_HI : R_MID;
  assign max_rate_d = (sink_rate < rate_cap_lim) ? sink_rate : rate_cap_lim;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      sink_lanes_q <= '0;
      max_rate_q   <= '0;
      hi_q         <= 1'b0;
      fix_q        <= 1'b0;
      cfg_q        <= 1'b0;
      demand_q     <= '0;
      exp_q        <= '0;
      rsel_q       <= '0;
      pick_q       <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      lanes        <= '0;
      rate         <= '0;
      mode_ok      <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            sink_lanes_q <= sink_lanes;
            max_rate_q   <= max_rate_d;
            hi_q         <= hi_rate_ok;
            fix_q        <= bridge_fix;
            cfg_q        <= cfg_valid;
            busy         <= 1'b1;
            done         <= 1'b0;
            st           <= ST_MUL;
          end
        end
        ST_MUL: begin
          if (mul_fin) begin
            demand_q <= mul_prod;
            exp_q    <= '0;
            st       <= ST_LANE;
          end
        end
        ST_LANE: begin
          if ((lanes_cur < sink_lanes_q) && (exp_q < EXP_W'(MAX_EXP)) && !fits) begin
            exp_q <= exp_q + EXP_W'(1);
          end else begin
            rsel_q <= 2'd0;
            st     <= ST_RATE;
          end
        end
        ST_RATE: begin
          if (fix_q) begin
            pick_q <= R_MID;
            st     <= ST_FIN;
          end else begin
            case (rsel_q)
              2'd0: begin
                if (fits) begin
                  pick_q <= R_LO;
                  st     <= ST_FIN;
                end else begin
                  rsel_q <= 2'd1;
                end
              end
              2'd1: begin
                if (fits) begin
                  pick_q <= R_MID;
                  st     <= ST_FIN;
                end else if (hi_q) begin
                  rsel_q <= 2'd2;
                end else begin
                  pick_q <= max_rate_q;
                  st     <= ST_FIN;
                end
              end
              default: begin
                pick_q <= fits ? R_HI : max_rate_q;
                st     <= ST_FIN;
              end
            endcase
          end
        end
        ST_FIN: begin
          lanes   <= lanes_cur;
          rate    <= pick_q;
          mode_ok <= cfg_q && !((pick_q == R_HI) && !hi_q);
          done    <= 1'b1;
          busy    <= 1'b0;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (st != ST_FIN)) |=> busy);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(done) |-> ($stable(lanes) && $stable(rate) && $stable(mode_ok)));

  // R2
  lanes_pow2_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($countones(lanes) == 1));

  // R4
  rate_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (rate <= R_HI));

  // R5
  bridge_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fix_q) |-> (rate == R_MID));

  // R6
  cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cfg_q) |-> !mode_ok);
endmodule

// File: tb/lrs_link_select_test.sv
module lrs_link_select_test;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W  = 20;
  localparam int BPC_W  = 4;
  localparam int RATE_W = 20;
  localparam int LANE_W = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [PIX_W-1:0]  pix_khz = '0;
  logic [BPC_W-1:0]  bpc = '0;
  logic [LANE_W-1:0] sink_lanes = '0;
  logic [RATE_W-1:0] sink_rate = '0;
  logic              hi_rate_ok = 1'b0;
  logic              bridge_fix = 1'b0;
  logic              cfg_valid = 1'b0;
  logic              busy, done, mode_ok;
  logic [LANE_W-1:0] lanes;
  logic [RATE_W-1:0] rate;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrs_link_select uut (
    .clk(clk), .rst(rst), .start(start), .pix_khz(pix_khz), .bpc(bpc),
    .sink_lanes(sink_lanes), .sink_rate(sink_rate), .hi_rate_ok(hi_rate_ok),
    .bridge_fix(bridge_fix), .cfg_valid(cfg_valid), .busy(busy), .done(done),
    .lanes(lanes), .rate(rate), .mode_ok(mode_ok)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int p, input int c, input int sl, input int sr,
                                input int hi, input int fx, input int cf,
                                output int el, output int er, output int eo);
    longint bpp, dem, mr;
    bpp = (c == 0) ? 24 : 3 * c;                       // R1
    dem = longint'(p) * bpp;
    mr  = (hi != 0) ? 540000 : 270000;                 // R3
    if (sr < mr) mr = sr;
    el = 1;                                            // R2
    while ((el < sl) && (el < 4)) begin
      if (dem <= mr * el * 8) break;
      el = el * 2;
    end
    if (fx != 0) er = 270000;                          // R5
    else if (dem <= 162000 * el * 8) er = 162000;      // R4
    else if (dem <= 270000 * el * 8) er = 270000;
    else if ((hi != 0) && (dem <= 540000 * el * 8)) er = 540000;
    else er = int'(mr);
    eo = ((cf != 0) && !((er == 540000) && (hi == 0))) ? 1 : 0;  // R6
  endfunction

  task automatic drive(input int p, input int c, input int sl, input int sr,
                       input int hi, input int fx, input int cf);
    pix_khz    = PIX_W'(p);
    bpc        = BPC_W'(c);
    sink_lanes = LANE_W'(sl);
    sink_rate  = RATE_W'(sr);
    hi_rate_ok = hi[0];
    bridge_fix = fx[0];
    cfg_valid  = cf[0];
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    if (!done) check("R7 done timeout", 0, 1);
  endtask

  task automatic run_one(input int p, input int c, input int sl, input int sr,
                         input int hi, input int fx, input int cf);
    int el, er, eo;
    model(p, c, sl, sr, hi, fx, cf, el, er, eo);
    @(negedge clk);
    drive(p, c, sl, sr, hi, fx, cf);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R1/R2 lanes", lanes, el);
    check("R3/R4 rate", rate, er);
    check("R6 mode_ok", mode_ok, eo);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=expired expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pix_list[13] = '{25000, 54000, 54001, 90000, 108000, 148500, 180000,
                         216000, 270000, 360000, 540000, 720000, 1000000};
    int bpc_list[5]  = '{0, 6, 8, 10, 12};
    int ln_list[3]   = '{1, 2, 4};
    int rt_list[3]   = '{162000, 270000, 540000};
    int el, er, eo;
    logic [LANE_W-1:0] h_l;
    logic [RATE_W-1:0] h_r;
    logic              h_o;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    check("R8 reset busy", busy, 0);
    check("R8 reset done", done, 0);
    check("R8 reset lanes", lanes, 0);
    check("R8 reset rate", rate, 0);
    check("R8 reset mode_ok", mode_ok, 0);

    // main sweep (R1 R2 R3 R4 R6)
    for (int a = 0; a < 13; a++)
      for (int b = 0; b < 5; b++)
        for (int l = 0; l < 3; l++)
          for (int r = 0; r < 3; r++)
            for (int h = 0; h < 2; h++)
              run_one(pix_list[a], bpc_list[b], ln_list[l], rt_list[r], h, 0, 1);

    // R5 bridge override
    for (int a = 0; a < 13; a++)
      for (int h = 0; h < 2; h++)
        run_one(pix_list[a], 8, 4, 540000, h, 1, 1);

    // R6 configuration absent
    for (int a = 0; a < 13; a += 3)
      run_one(pix_list[a], 0, 4, 540000, 1, 0, 0);

    // R2 sink limit above hardware maximum behaves as 4
    run_one(1000000, 12, 7, 540000, 1, 0, 1);
    run_one(54001, 0, 0, 270000, 0, 0, 1);

    // R7 start during busy is ignored
    model(720000, 10, 4, 540000, 1, 0, 1, el, er, eo);
    @(negedge clk);
    drive(720000, 10, 4, 540000, 1, 0, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy after start", busy, 1);
    check("R7 done cleared", done, 0);
    @(negedge clk);
    drive(25000, 0, 1, 162000, 0, 1, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R7 ignored start lanes", lanes, el);
    check("R7 ignored start rate", rate, er);
    check("R7 ignored start mode_ok", mode_ok, eo);
    check("R7 busy low at done", busy, 0);

    // R8 outputs held while inputs change
    h_l = lanes;
    h_r = rate;
    h_o = mode_ok;
    drive(1000000, 12, 2, 162000, 0, 0, 0);
    repeat (25) @(negedge clk);
    check("R8 hold lanes", lanes, h_l);
    check("R8 hold rate", rate, h_r);
    check("R8 hold mode_ok", mode_ok, h_o);
    check("R8 hold done", done, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule